// File: doc/BRIEF.md
# Tunable Quadrature Oscillator Phase Front End

This block turns a 28-bit tuning word into a running phase and a quadrature pair of 16-bit signed samples. Software writes the tuning word one byte at a time into a staging word. A selectable commit policy moves the staged word into the active frequency register. The policy is one of four: follow the staging word on every clock, commit on a software load strobe, commit when the accumulator sync strobe falls, or commit when the system sync strobe falls.

Each clock the active frequency is added into a 28-bit phase accumulator that wraps modulo 2^28. The output tone is therefore clock_rate × word / 2^28. The top eight phase bits index a quarter-wave table, and mirroring and negating that table gives sine and cosine. The mixer and the filters downstream are outside this block.

Top module: `tune_nco`

## Requirements
- R1: After reset the staged word, the active frequency and the phase are all zero. The phase holds at zero until a non-zero word is committed.
- R2: Byte lane select 0 writes word bits 7:0, select 1 writes bits 15:8, select 2 writes bits 23:16, and select 3 writes bits 27:24 from data bits 3:0. Data bits 7:4 of lane 3 are discarded.
- R3: On every clock the phase becomes (phase + active frequency) mod 2^28.
- R4: In policy code 0 (follow), the active frequency equals the staged word one clock after the write that changed it.
- R5: In policy code 1 (software), a one-clock high pulse on `sw_load` commits the staged word on the clock after the pulse. The load bit then clears by itself. Later writes with no new pulse leave the active frequency unchanged.
- R6: In policy code 2, the staged word is committed at the first clock edge where `acc_sync` is sampled low after being sampled high. A fall of `sys_sync` has no effect in this policy.
- R7: In policy code 3, the staged word is committed at the first clock edge where `sys_sync` is sampled low after being sampled high. A fall of `acc_sync` has no effect in this policy.
- R8: Commits in policies 2 and 3 happen on the falling edge, not on the level. A strobe held low does not pick up later writes. `sw_load` has no effect outside policy 1.
- R9: When a commit and a byte write fall in the same clock, the active register takes the staged word as it stood before that write.
- R10: With k equal to phase bits 27:20, `sin_out` = round(32767·sin(2π(k+0.5)/256)) and `cos_out` = round(32767·cos(2π(k+0.5)/256)), each within one LSB. Both outputs follow the phase output in the same cycle, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 2 | Byte lane select for the staged word |
| wr_data | input | 8 | Byte write data |
| load_mode | input | 2 | Commit policy: 0 follow, 1 software, 2 accumulator-sync fall, 3 system-sync fall |
| sw_load | input | 1 | Software load bit write pulse |
| acc_sync | input | 1 | Accumulator sync strobe, idles high |
| sys_sync | input | 1 | System sync strobe, idles high |
| phase | output | 28 | Phase accumulator value |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |

## Verification
A byte write and a commit of the staged word can fall in the same clock. This matters most in the software policy, where the delayed load bit fires one clock after its pulse. The bench lines up a write to lane 2 with that delayed load bit. It then measures the phase step and expects it to equal the word from before the write. A second pulse follows, and the bench expects the newly written word to be committed.

// File: rtl/tune_nco_pkg.sv
package tune_nco_pkg;

    typedef enum logic [1:0] {
        LD_FOLLOW   = 2'd0,
        LD_SOFT     = 2'd1,
        LD_ACC_FALL = 2'd2,
        LD_SYS_FALL = 2'd3
    } load_pol_e;

    // Odd power series for sin(x) on 0..pi/2, evaluated at elaboration
    function automatic real series_sine(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n < 8; n++) begin
            term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Quarter-wave level for entry i of q entries, sampled at half steps
    function automatic int wave_level(input int i, input int q, input int amp);
        real x;
        x = 1.5707963267948966 * (real'(i) + 0.5) / real'(q);
        return int'(real'(amp) * series_sine(x));
    endfunction

endpackage

// File: rtl/tune_nco_stage.sv
module tune_nco_stage #(
    parameter int FREQ_W = 28,
    parameter int BYTE_W = 8,
    localparam int N_LANES = (FREQ_W + BYTE_W - 1) / BYTE_W,
    localparam int SEL_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [FREQ_W-1:0] stage_word
);
    localparam int WIDE_W = N_LANES * BYTE_W;

    typedef struct packed {
        logic [FREQ_W-1:0] word;
    } stage_t;

    stage_t stg_d, stg_q;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        stg_d = stg_q;
        wide  = WIDE_W'(stg_q.word);
        if (wr_en) begin
            for (int lane = 0; lane < N_LANES; lane++) begin
                if (wr_sel == SEL_W'(lane)) begin
                    wide[lane*BYTE_W +: BYTE_W] = wr_data;
                end
            end
        end
        // bits beyond the word width fall away here
        stg_d.word = wide[FREQ_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign stage_word = stg_q.word;
endmodule

// File: rtl/tune_nco_commit.sv
module tune_nco_commit #(
    parameter int FREQ_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        load_mode,
    input  logic              sw_load,
    input  logic              acc_sync,
    input  logic              sys_sync,
    input  logic [FREQ_W-1:0] stage_word,
    output logic [FREQ_W-1:0] act_freq
);
    import tune_nco_pkg::*;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic              soft_go;
        logic              acc_prev;
        logic              sys_prev;
    } commit_t;

    commit_t   cm_d, cm_q;
    load_pol_e policy;
    logic      acc_fall;
    logic      sys_fall;
    logic      commit;

    always_comb begin
        policy   = load_pol_e'(load_mode);
        cm_d     = cm_q;
        // the load bit lives for exactly one clock after its pulse
        cm_d.soft_go  = sw_load;
        cm_d.acc_prev = acc_sync;
        cm_d.sys_prev = sys_sync;
        acc_fall = cm_q.acc_prev & ~acc_sync;
        sys_fall = cm_q.sys_prev & ~sys_sync;
        case (policy)
            LD_FOLLOW:   commit = 1'b1;
            LD_SOFT:     commit = cm_q.soft_go;
            LD_ACC_FALL: commit = acc_fall;
            default:     commit = sys_fall;
        endcase
        if (commit) cm_d.freq = stage_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cm_q <= '0;
        else        cm_q <= cm_d;
    end

    assign act_freq = cm_q.freq;
endmodule

// File: rtl/tune_nco_accum.sv
module tune_nco_accum #(
    parameter int FREQ_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] act_freq,
    output logic [FREQ_W-1:0] phase
);
    typedef struct packed {
        logic [FREQ_W-1:0] ph;
    } acc_t;

    acc_t ac_d, ac_q;

    always_comb begin
        ac_d    = ac_q;
        ac_d.ph = ac_q.ph + act_freq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    assign phase = ac_q.ph;
endmodule

// File: rtl/tune_nco_qlut.sv
module tune_nco_qlut #(
    parameter int LUT_AW = 6,
    parameter int SAMP_W = 16,
    localparam int QN  = 1 << LUT_AW,
    localparam int AMP = (1 << (SAMP_W - 1)) - 1
) (
    input  logic [LUT_AW+1:0]        phase_top,
    output logic signed [SAMP_W-1:0] sin_out,
    output logic signed [SAMP_W-1:0] cos_out
);
    logic [SAMP_W-1:0] rom [QN];

    for (genvar gi = 0; gi < QN; gi++) begin : g_rom
        localparam int LEVEL = tune_nco_pkg::wave_level(gi, QN, AMP);
        assign rom[gi] = SAMP_W'(LEVEL);
    end

    logic [1:0]               quad_s;
    logic [1:0]               quad_c;
    logic [LUT_AW-1:0]        idx;
    logic signed [SAMP_W-1:0] mag_s;
    logic signed [SAMP_W-1:0] mag_c;

    always_comb begin
        quad_s = phase_top[LUT_AW+1:LUT_AW];
        quad_c = quad_s + 2'd1;   // cosine leads sine by a quarter turn
        idx    = phase_top[LUT_AW-1:0];
        mag_s  = $signed(rom[quad_s[0] ? ~idx : idx]);
        mag_c  = $signed(rom[quad_c[0] ? ~idx : idx]);
        sin_out = quad_s[1] ? -mag_s : mag_s;
        cos_out = quad_c[1] ? -mag_c : mag_c;
    end
endmodule

// File: rtl/tune_nco.sv
module tune_nco #(
    parameter int FREQ_W = 28,
    parameter int BYTE_W = 8,
    parameter int LUT_AW = 6,
    parameter int SAMP_W = 16,
    localparam int N_LANES = (FREQ_W + BYTE_W - 1) / BYTE_W,
    localparam int SEL_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        load_mode,
    input  logic              sw_load,
    input  logic              acc_sync,
    input  logic              sys_sync,
    output logic [FREQ_W-1:0] phase,
    output logic [SAMP_W-1:0] sin_out,
    output logic [SAMP_W-1:0] cos_out
);
    logic [FREQ_W-1:0] stage_word;
    logic [FREQ_W-1:0] act_freq;
    logic signed [SAMP_W-1:0] sin_w;
    logic signed [SAMP_W-1:0] cos_w;

    tune_nco_stage #(.FREQ_W(FREQ_W), .BYTE_W(BYTE_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .stage_word(stage_word)
    );

    tune_nco_commit #(.FREQ_W(FREQ_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .sw_load(sw_load),
        .acc_sync(acc_sync), .sys_sync(sys_sync), .stage_word(stage_word),
        .act_freq(act_freq)
    );

    tune_nco_accum #(.FREQ_W(FREQ_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .act_freq(act_freq), .phase(phase)
    );

    tune_nco_qlut #(.LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_qlut (
        .phase_top(phase[FREQ_W-1 -: LUT_AW+2]),
        .sin_out(sin_w), .cos_out(cos_w)
    );

    assign sin_out = sin_w;
    assign cos_out = cos_w;
endmodule

// File: rtl/tune_nco_chk.sv
module tune_nco_chk #(
    parameter int FREQ_W = 28,
    parameter int SAMP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        load_mode,
    input logic              sw_load,
    input logic              acc_sync,
    input logic              sys_sync,
    input logic [FREQ_W-1:0] stage_word,
    input logic [FREQ_W-1:0] act_freq,
    input logic [FREQ_W-1:0] phase,
    input logic [SAMP_W-1:0] sin_out,
    input logic [SAMP_W-1:0] cos_out
);
    p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase == FREQ_W'($past(phase) + $past(act_freq)));

    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mode == 2'd0) |=> act_freq == $past(stage_word));

    p_soft_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_mode) == 2'd1 && act_freq != $past(act_freq)) |-> $past(sw_load, 2));

    p_acc_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_mode) == 2'd2 && act_freq != $past(act_freq))
            |-> ($past(acc_sync, 2) && !$past(acc_sync)));

    p_sys_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_mode) == 2'd3 && act_freq != $past(act_freq))
            |-> ($past(sys_sync, 2) && !$past(sys_sync)));

    p_sin_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[FREQ_W-1] == 1'b0) |-> ($signed(sin_out) > 0));

    p_cos_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[FREQ_W-1] == phase[FREQ_W-2]) |-> ($signed(cos_out) > 0));
endmodule

bind tune_nco tune_nco_chk #(.FREQ_W(FREQ_W), .SAMP_W(SAMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .sw_load(sw_load),
    .acc_sync(acc_sync), .sys_sync(sys_sync), .stage_word(stage_word),
    .act_freq(act_freq), .phase(phase), .sin_out(sin_out), .cos_out(cos_out)
);

// File: tb/tune_nco_bench.sv
`timescale 1ns/1ps
module tune_nco_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [1:0]  load_mode = 2'd0;
    logic        sw_load = 1'b0;
    logic        acc_sync = 1'b1;
    logic        sys_sync = 1'b1;
    logic [27:0] phase;
    logic [15:0] sin_out;
    logic [15:0] cos_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tune_nco u_tune_nco (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .load_mode(load_mode), .sw_load(sw_load),
        .acc_sync(acc_sync), .sys_sync(sys_sync), .phase(phase),
        .sin_out(sin_out), .cos_out(cos_out)
    );

    task automatic check_eq(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp);
        total++;
        if (act - exp > 1 || exp - act > 1) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wave_exp(input logic [27:0] ph, input bit want_cos);
        real a;
        a = 6.283185307179586 * (real'(ph[27:20]) + 0.5) / 256.0;
        return want_cos ? int'(32767.0 * $cos(a)) : int'(32767.0 * $sin(a));
    endfunction

    // call at a falling edge; returns the active frequency seen during that cycle
    task automatic meas_step(output logic [27:0] s);
        logic [27:0] p0;
        p0 = phase;
        @(negedge clk);
        s = phase - p0;
    endtask

    task automatic put_byte(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_word(input logic [27:0] w);
        put_byte(2'd0, w[7:0]);
        put_byte(2'd1, w[15:8]);
        put_byte(2'd2, w[23:16]);
        put_byte(2'd3, {4'h0, w[27:24]});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [27:0] s;
        idle(3);
        check_eq("R1 phase after reset", phase, 0);
        meas_step(s);
        check_eq("R1 active after reset", s, 0);
        check_near("R1 sin at zero phase", $signed(sin_out), wave_exp(phase, 1'b0));
        check_near("R1 cos at zero phase", $signed(cos_out), wave_exp(phase, 1'b1));
    endtask

    task automatic t_lanes_follow;
        logic [27:0] s;
        load_mode = 2'd0;
        put_byte(2'd0, 8'h78);
        put_byte(2'd1, 8'h56);
        put_byte(2'd2, 8'h34);
        idle(2);
        put_byte(2'd3, 8'hF2);   // upper nibble must vanish
        meas_step(s);
        check_eq("R4 step in write cycle still old", s, 28'h0345678);
        meas_step(s);
        check_eq("R2 R4 step after top lane write", s, 28'h2345678);
    endtask

    task automatic t_wrap;
        logic [27:0] p0;
        int wraps;
        wraps = 0;
        put_word(28'hC000001);
        idle(2);
        for (int i = 0; i < 6; i++) begin
            p0 = phase;
            @(negedge clk);
            if (phase < p0) wraps++;
            check_eq("R3 phase step modulo", phase, 28'(p0 + 28'hC000001));
        end
        check_eq("R3 wrap observed", (wraps > 0) ? 1 : 0, 1);
    endtask

    task automatic t_soft;
        logic [27:0] s;
        load_mode = 2'd1;
        put_word(28'h0100000);
        idle(3);
        meas_step(s);
        check_eq("R5 staged word not committed without pulse", s, 28'hC000001);
        sw_load = 1'b1;
        @(negedge clk);
        sw_load = 1'b0;
        meas_step(s);
        check_eq("R5 load bit not yet applied", s, 28'hC000001);
        meas_step(s);
        check_eq("R5 committed after pulse", s, 28'h0100000);
        put_word(28'h0200000);
        idle(3);
        meas_step(s);
        check_eq("R5 bit self cleared", s, 28'h0100000);
    endtask

    task automatic t_acc;
        logic [27:0] s;
        load_mode = 2'd2;
        put_word(28'h0030000);
        sw_load = 1'b1;
        @(negedge clk);
        sw_load = 1'b0;
        sys_sync = 1'b0;
        idle(2);
        sys_sync = 1'b1;
        idle(2);
        meas_step(s);
        check_eq("R6 R8 other strobe and sw_load ignored", s, 28'h0100000);
        acc_sync = 1'b0;
        meas_step(s);
        check_eq("R6 before fall edge", s, 28'h0100000);
        meas_step(s);
        check_eq("R6 committed at fall", s, 28'h0030000);
        put_word(28'h0040000);
        idle(3);
        meas_step(s);
        check_eq("R8 held low does not reload", s, 28'h0030000);
        acc_sync = 1'b1;
        idle(2);
    endtask

    task automatic t_sys;
        logic [27:0] s;
        load_mode = 2'd3;
        put_word(28'h0050000);
        acc_sync = 1'b0;
        idle(2);
        acc_sync = 1'b1;
        idle(2);
        meas_step(s);
        check_eq("R7 accumulator strobe ignored", s, 28'h0030000);
        sys_sync = 1'b0;
        meas_step(s);
        check_eq("R7 before fall edge", s, 28'h0030000);
        meas_step(s);
        check_eq("R7 committed at fall", s, 28'h0050000);
        sys_sync = 1'b1;
        idle(2);
    endtask

    task automatic t_collide;
        logic [27:0] s;
        load_mode = 2'd1;
        idle(1);
        sw_load = 1'b1;
        @(negedge clk);
        sw_load = 1'b0;
        put_byte(2'd2, 8'h07);   // write lands on the commit edge
        meas_step(s);
        check_eq("R9 commit takes pre-write word", s, 28'h0050000);
        sw_load = 1'b1;
        @(negedge clk);
        sw_load = 1'b0;
        idle(1);
        meas_step(s);
        check_eq("R9 later pulse takes written word", s, 28'h0070000);
    endtask

    task automatic t_wave;
        load_mode = 2'd0;
        put_word(28'h0310123);
        idle(2);
        for (int i = 0; i < 90; i++) begin
            check_near("R10 sine sample", $signed(sin_out), wave_exp(phase, 1'b0));
            check_near("R10 cosine sample", $signed(cos_out), wave_exp(phase, 1'b1));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_lanes_follow();
        t_wrap();
        t_soft();
        t_acc();
        t_sys();
        t_collide();
        t_wave();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule